// File: doc/BRIEF.md
# Charger Detection Sequencer

This block runs a charger detection flow in hardware. After a `start` pulse it first checks for data contact. It enables the D+ current source and forces the D− pull-down on. It then reads a D+ status bit, which is already glitch-filtered outside this block, at a fixed sampling period until the bit has read high on enough consecutive samples. If the contact does not appear within a long timeout, the flow moves on anyway.

Next the block runs the primary comparison. It selects that detection type, enables the voltage source and the comparator, and forces the pull-down off. If the primary comparison reads high, a secondary comparison follows.

Every control change starts a fresh settle interval. Status is read only after that interval has passed. All intervals are counted in ticks of an external microsecond strobe. Between phases, every control output drops to zero for one cycle. When the flow ends, `done` pulses for one cycle and `result` carries a two-bit port type code.

Top module: `chgdet_seq`

## Requirements
- R1: While reset is low, and in idle after reset, every control output and `done` are 0, and `start` asserted during reset has no effect.
- R2: A `start` pulse in idle raises `idp_src_en` and `dm_pd_on` together, with the other controls at 0, for the whole contact phase. A `start` while a run is in progress changes neither the timing nor the result.
- R3: `dp_stat` is ignored during the first SETTLE_DP_US ticks of the contact phase. After that, it is sampled only once every SAMPLE_US ticks.
- R4: Contact is declared on the DBNC_SAMPLES-th consecutive high sample, which ends the contact phase on that tick. A low sample restarts the count.
- R5: When DCD_TIMEOUT_US ticks have elapsed since the contact phase began without contact, the phase ends on that tick and the run is marked as timed out. If contact and the timeout fall on the same tick, contact wins.
- R6: Before each comparison phase there is exactly one cycle with all control outputs at 0.
- R7: The primary phase drives `det_sel`=0 and `vsrc_en`, `cmp_en` and `dm_pd_off` high for SETTLE_CMP_US ticks. `cmp_stat` is sampled only on the last tick of that interval.
- R8: If the primary sample is 0, the result is 1 (standard port), or 0 (none) if the contact phase timed out.
- R9: If the primary sample is 1, a secondary phase with `det_sel`=1 follows for SETTLE_CMP_US ticks, and `det_sel` stays stable throughout. A secondary sample of 1 gives result 3 (dedicated charger), and 0 gives result 2 (charging downstream port).
- R10: `done` is high for exactly one cycle with all controls at 0, `result` is valid in that cycle, and the block then returns to idle.
- R11: Every interval advances only on cycles with `us_tick` high. With no ticks, the current phase and its controls hold.
- R12: `dm_pd_on` and `dm_pd_off` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a detection run (taken in idle only) |
| us_tick | input | 1 | One-cycle strobe each microsecond |
| dp_stat | input | 1 | Filtered D+ line status |
| cmp_stat | input | 1 | Filtered detection comparator output |
| idp_src_en | output | 1 | D+ contact current source enable |
| dm_pd_on | output | 1 | Force D− pull-down active |
| dm_pd_off | output | 1 | Force D− pull-down inactive |
| det_sel | output | 1 | Detection type: 0 primary, 1 secondary |
| vsrc_en | output | 1 | Detection voltage source enable |
| cmp_en | output | 1 | Detection comparator enable |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 2 | 0 none, 1 standard, 2 charging downstream, 3 dedicated |

## Verification
The bench builds the block with a D+ settle of 5 ticks, a comparator settle of 3 ticks, a 4-tick sample period, 3 debounce samples and a 60-tick timeout, and most runs hold the tick high. With these values a full run takes fewer than 100 cycles. Six D+ waveforms are swept against all four comparator outcomes: early contact, a late rise, a glitch that resets the count, a rise just beyond the timeout, a pulse that ends before the first sample, and no contact at all. Further runs stall the tick for 50 cycles and inject `start` pulses while a run is in progress.

// File: rtl/chgdet_pkg.sv
// Package: shared state encoding, result codes and control decode for the
// charger detection sequencer. Assumes a Moore-style decode of controls.
package chgdet_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DCD_SETTLE,
        ST_DCD_POLL,
        ST_GAP_A,
        ST_PRI,
        ST_GAP_B,
        ST_SEC,
        ST_REPORT
    } cd_state_e;

    localparam logic [1:0] RES_NONE  = 2'd0;
    localparam logic [1:0] RES_STD   = 2'd1;
    localparam logic [1:0] RES_CHGDN = 2'd2;
    localparam logic [1:0] RES_DEDIC = 2'd3;

    typedef struct packed {
        logic idp;
        logic pd_on;
        logic pd_off;
        logic sel;
        logic vsrc;
        logic cmp;
    } cd_ctrl_t;

    // Control pattern driven in each state; gaps and idle drive nothing.
    function automatic cd_ctrl_t ctrl_for(cd_state_e s);
        cd_ctrl_t c;
        c = '0;
        case (s)
            ST_DCD_SETTLE, ST_DCD_POLL: begin
                c.idp   = 1'b1;
                c.pd_on = 1'b1;
            end
            ST_PRI: begin
                c.pd_off = 1'b1;
                c.vsrc   = 1'b1;
                c.cmp    = 1'b1;
            end
            ST_SEC: begin
                c.pd_off = 1'b1;
                c.sel    = 1'b1;
                c.vsrc   = 1'b1;
                c.cmp    = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/chgdet_tick_timer.sv
// Tick timer: counts us_tick strobes from a clear and flags the tick that
// completes `limit` ticks. Assumes limit >= 1 and is stable while counting.
module chgdet_tick_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         expire
);

    logic [W-1:0] cnt_q;

    // Expiry is the tick on which the count reaches the limit.
    assign expire = tick && (cnt_q == limit - W'(1));

    // Count ticks; wrap on expiry, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= expire ? '0 : cnt_q + W'(1);
        end
    end

endmodule

// File: rtl/chgdet_dbnc.sv
// Debounce counter: counts consecutive high samples of an already filtered
// level and flags the sample that completes DBNC_SAMPLES of them.
// Assumes DBNC_SAMPLES >= 1.
module chgdet_dbnc #(
    parameter int DBNC_SAMPLES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sample,
    input  logic level,
    output logic hit
);

    localparam int HW = $clog2(DBNC_SAMPLES + 1);

    logic [HW-1:0] run_q;

    // The run is complete when this high sample is the last one needed.
    assign hit = sample && level && (run_q == HW'(DBNC_SAMPLES - 1));

    // Track the length of the current run of high samples.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_q <= '0;
        end else if (sample) begin
            run_q <= level ? run_q + HW'(1) : '0;
        end
    end

endmodule

// File: rtl/chgdet_seq.sv
// Charger detection sequencer: contact check with debounce and timeout, then
// primary and optional secondary comparison, each after a settle interval.
// Assumes us_tick is a one-cycle strobe and that the status inputs are already
// glitch-filtered. Controls are decoded from the registered state.
module chgdet_seq #(
    parameter int SETTLE_DP_US   = 560,
    parameter int SETTLE_CMP_US  = 140,
    parameter int SAMPLE_US      = 1000,
    parameter int DBNC_SAMPLES   = 10,
    parameter int DCD_TIMEOUT_US = 900000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       us_tick,
    input  logic       dp_stat,
    input  logic       cmp_stat,
    output logic       idp_src_en,
    output logic       dm_pd_on,
    output logic       dm_pd_off,
    output logic       det_sel,
    output logic       vsrc_en,
    output logic       cmp_en,
    output logic       done,
    output logic [1:0] result
);
    import chgdet_pkg::*;

    localparam int SET_MAX = (SETTLE_DP_US > SETTLE_CMP_US) ? SETTLE_DP_US : SETTLE_CMP_US;
    localparam int SET_W   = $clog2(SET_MAX + 1);
    localparam int SMP_W   = $clog2(SAMPLE_US + 1);
    localparam int TO_W    = $clog2(DCD_TIMEOUT_US + 1);

    cd_state_e  state_q, state_d;
    logic       tmo_q;
    logic [1:0] res_q;
    cd_ctrl_t   ctl;

    logic             set_exp, smp_exp, to_exp, contact;
    logic             in_dcd, in_poll, tmo_evt;
    logic [SET_W-1:0] set_limit;

    assign in_dcd  = (state_q == ST_DCD_SETTLE) || (state_q == ST_DCD_POLL);
    assign in_poll = (state_q == ST_DCD_POLL);

    // Settle length: D+ settle in the contact phase, comparator settle otherwise.
    assign set_limit = (state_q == ST_DCD_SETTLE) ? SET_W'(SETTLE_DP_US)
                                                  : SET_W'(SETTLE_CMP_US);

    chgdet_tick_timer #(.W(SET_W)) u_settle (
        .clk(clk), .rst_n(rst_n), .clr(state_d != state_q), .tick(us_tick),
        .limit(set_limit), .expire(set_exp)
    );

    chgdet_tick_timer #(.W(SMP_W)) u_sample (
        .clk(clk), .rst_n(rst_n), .clr(!in_poll), .tick(us_tick),
        .limit(SMP_W'(SAMPLE_US)), .expire(smp_exp)
    );

    chgdet_tick_timer #(.W(TO_W)) u_timeout (
        .clk(clk), .rst_n(rst_n), .clr(!in_dcd), .tick(us_tick),
        .limit(TO_W'(DCD_TIMEOUT_US)), .expire(to_exp)
    );

    chgdet_dbnc #(.DBNC_SAMPLES(DBNC_SAMPLES)) u_dbnc (
        .clk(clk), .rst_n(rst_n), .clr(!in_poll), .sample(smp_exp),
        .level(dp_stat), .hit(contact)
    );

    // Timeout counts only if contact did not complete on the same tick.
    assign tmo_evt = in_dcd && to_exp && !(in_poll && contact);

    // Next-state selection for the detection flow.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:       if (start) state_d = ST_DCD_SETTLE;
            ST_DCD_SETTLE: if (to_exp) state_d = ST_GAP_A;
                           else if (set_exp) state_d = ST_DCD_POLL;
            ST_DCD_POLL:   if (contact || to_exp) state_d = ST_GAP_A;
            ST_GAP_A:      state_d = ST_PRI;
            ST_PRI:        if (set_exp) state_d = cmp_stat ? ST_GAP_B : ST_REPORT;
            ST_GAP_B:      state_d = ST_SEC;
            ST_SEC:        if (set_exp) state_d = ST_REPORT;
            ST_REPORT:     state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Timeout flag: cleared at start, set when the contact window runs out.
    always_ff @(posedge clk) begin
        if (!rst_n)                           tmo_q <= 1'b0;
        else if (state_q == ST_IDLE && start) tmo_q <= 1'b0;
        else if (tmo_evt)                     tmo_q <= 1'b1;
    end

    // Result code captured at the deciding comparator sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= RES_NONE;
        end else if (state_q == ST_PRI && set_exp && !cmp_stat) begin
            res_q <= tmo_q ? RES_NONE : RES_STD;
        end else if (state_q == ST_SEC && set_exp) begin
            res_q <= cmp_stat ? RES_DEDIC : RES_CHGDN;
        end
    end

    // Control outputs decoded from the current state.
    assign ctl        = ctrl_for(state_q);
    assign idp_src_en = ctl.idp;
    assign dm_pd_on   = ctl.pd_on;
    assign dm_pd_off  = ctl.pd_off;
    assign det_sel    = ctl.sel;
    assign vsrc_en    = ctl.vsrc;
    assign cmp_en     = ctl.cmp;
    assign done       = (state_q == ST_REPORT);
    assign result     = res_q;

endmodule

// Checker: protocol properties of the sequencer outputs, bound to every instance.
module chgdet_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic us_tick,
    input logic idp_src_en,
    input logic dm_pd_on,
    input logic dm_pd_off,
    input logic det_sel,
    input logic vsrc_en,
    input logic done
);

    AST_PULLDOWN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(dm_pd_on && dm_pd_off)); // R12

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(idp_src_en || dm_pd_on || dm_pd_off || vsrc_en || det_sel)); // R10

    AST_PHASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsrc_en) |-> $past(!idp_src_en && !vsrc_en)); // R6

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (vsrc_en && $past(vsrc_en)) |-> $stable(det_sel)); // R9

    AST_DCD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (idp_src_en && !us_tick) |=> idp_src_en); // R11

    AST_CMP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (vsrc_en && !us_tick) |=> (vsrc_en && $stable(det_sel))); // R11

endmodule

bind chgdet_seq chgdet_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .idp_src_en(idp_src_en),
    .dm_pd_on(dm_pd_on), .dm_pd_off(dm_pd_off), .det_sel(det_sel),
    .vsrc_en(vsrc_en), .done(done)
);

// File: tb/chgdet_seq_test.sv
`timescale 1ns/1ps
// Bench: sweeps D+ waveforms against comparator outcomes on a small
// configuration, and computes phase lengths and result codes arithmetically.
module chgdet_seq_test;

    localparam int SD = 5;
    localparam int SC = 3;
    localparam int SP = 4;
    localparam int DB = 3;
    localparam int TO = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic us_tick = 1'b1;
    logic dp_stat = 1'b0;
    logic cmp_stat = 1'b0;
    logic idp_src_en, dm_pd_on, dm_pd_off, det_sel, vsrc_en, cmp_en, done;
    logic [1:0] result;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    chgdet_seq #(
        .SETTLE_DP_US(SD), .SETTLE_CMP_US(SC), .SAMPLE_US(SP),
        .DBNC_SAMPLES(DB), .DCD_TIMEOUT_US(TO)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .us_tick(us_tick),
        .dp_stat(dp_stat), .cmp_stat(cmp_stat), .idp_src_en(idp_src_en),
        .dm_pd_on(dm_pd_on), .dm_pd_off(dm_pd_off), .det_sel(det_sel),
        .vsrc_en(vsrc_en), .cmp_en(cmp_en), .done(done), .result(result)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // D+ level seen at edge k after start.
    function automatic bit dp_val(input int pat, input int k);
        case (pat)
            0: return 1'b1;
            1: return 1'b0;
            2: return k >= 30;
            3: return !(k >= 20 && k <= 22);
            4: return k >= 50;
            default: return k < 9;
        endcase
    endfunction

    // Contact-phase length and timeout flag from the sampling rules.
    task automatic exp_dcd(input int pat, output int cyc, output bit tmo);
        int hits = 0;
        cyc = TO;
        tmo = 1'b1;
        for (int m = 1; SD + m * SP <= TO; m++) begin
            hits = dp_val(pat, SD + m * SP) ? hits + 1 : 0;
            if (hits == DB) begin
                cyc = SD + m * SP;
                tmo = 1'b0;
                break;
            end
        end
    endtask

    task automatic run_case(input int pat, input bit pv, input bit sv,
                            input bit extra, input bit freeze);
        int dcd = 0, pdon = 0, pri = 0, sec = 0, zero = 0, bad = 0, ph = 0;
        int res = -1, i = 0, e_dcd, e_res;
        bit seen = 1'b0, tmo, truth;
        exp_dcd(pat, e_dcd, tmo);
        if (freeze) e_dcd += 50;
        e_res = !pv ? (tmo ? 0 : 1) : (sv ? 3 : 2);
        @(negedge clk);
        start = 1'b1;
        us_tick = 1'b1;
        @(negedge clk);
        start = 1'b0;
        i = 1;
        while (!seen && i < 1000) begin
            if (idp_src_en) dcd++;
            if (dm_pd_on) pdon++;
            if (vsrc_en && !det_sel) pri++;
            if (vsrc_en && det_sel) sec++;
            if (vsrc_en && !(cmp_en && dm_pd_off && !dm_pd_on && !idp_src_en)) bad++;
            if (idp_src_en && (vsrc_en || cmp_en || dm_pd_off || det_sel)) bad++;
            if (!(idp_src_en || dm_pd_on || dm_pd_off || det_sel || vsrc_en || cmp_en) && !done) zero++;
            if (done) begin
                seen = 1'b1;
                res = result;
            end
            if (freeze && i == 52) begin
                chk("R11", "contact phase held without ticks", idp_src_en, 1);
                chk("R11", "no done without ticks", done, 0);
            end
            ph = vsrc_en ? ph + 1 : 0;
            truth = det_sel ? sv : pv;
            cmp_stat = (ph == SC) ? truth : !truth;
            dp_stat = dp_val(pat, i);
            us_tick = !(freeze && i >= 3 && i < 53);
            start = extra && (i == 10 || i == 20);
            if (!seen) begin
                @(negedge clk);
                i++;
            end
        end
        start = 1'b0;
        us_tick = 1'b1;
        if (!seen) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog: actual %0d expected done within %0d cycles", i, 1000);
            return;
        end
        chk(tmo ? "R5" : "R4", "contact phase cycles (R3 sampling)", dcd, e_dcd);
        chk("R2", "pull-down on cycles match source", pdon, e_dcd);
        chk("R6", "all-zero gap cycles", zero, pv ? 2 : 1);
        chk("R7", "primary phase cycles", pri, SC);
        chk("R7", "control combination faults", bad, 0);
        chk("R9", "secondary phase cycles", sec, pv ? SC : 0);
        chk(pv ? "R9" : "R8", "result code", res, e_res);
        @(negedge clk);
        chk("R10", "done single pulse", done, 0);
        chk("R10", "idle after done", idp_src_en | vsrc_en | dm_pd_off, 0);
        @(negedge clk);
    endtask

    initial begin
        start = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1", "controls in reset", {idp_src_en, dm_pd_on, dm_pd_off, det_sel, vsrc_en, cmp_en}, 0);
        chk("R1", "done in reset", done, 0);
        start = 1'b0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "controls idle after reset", {idp_src_en, dm_pd_on, dm_pd_off, det_sel, vsrc_en, cmp_en}, 0);
        chk("R1", "done idle after reset", done, 0);
        for (int pat = 0; pat < 6; pat++) begin
            for (int c = 0; c < 4; c++) begin
                run_case(pat, c[1], c[0], 1'b0, 1'b0);
            end
        end
        run_case(0, 1'b1, 1'b1, 1'b1, 1'b0); // R2 start while busy
        run_case(3, 1'b1, 1'b0, 1'b1, 1'b0); // R2 start while busy
        run_case(0, 1'b0, 1'b0, 1'b0, 1'b1); // R11 stalled ticks
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule